// File: doc/BRIEF.md
# Training Mailbox Handshake Monitor

This block takes the place of driver software while a memory-PHY training engine runs. A start pulse sets it going. From then on it is the master on a single-beat register port: it polls the engine's mailbox status, reads each posted message and acknowledges it with a two-phase handshake. Every word it collects appears on a tagged output for one cycle. Monitoring stops when the engine reports pass or fail, or when a poll wait lasts longer than a fixed number of status reads.

A major code that starts a stream changes how the next messages are read. The first stream word gives a count N, then exactly N argument words follow. Each stream word is 32 bits and is built from two 16-bit register reads. Register word indices become byte addresses as `BASE_ADDR + 4*index`.

Top module: `mbox_monitor`

## Requirements
- R1: After reset, all outputs are low and no bus request is made until `start_i` is seen high.
- R2: A bus request stays high, with address, write-enable and write data stable, until the cycle in which `bus_ack_i` is high. It drops in the following cycle (single beat).
- R3: Before reading any message, the block reads status (index 0xd0004, byte offset 0x340010) repeatedly until bit 0 reads 0.
- R4: A major message is one read of the low data register (index 0xd0032, offset 0x3400C8). It is output with tag 0 and data `{16'h0, rdata[15:0]}`.
- R5: A stream word reads the high register (index 0xd0034, offset 0x3400D0) and then the low register. The output is `{high[15:0], low[15:0]}`.
- R6: After each message read, the block writes 0 to the acknowledge register (index 0xd0031, offset 0x3400C4). It then polls status until bit 0 reads 1, then writes 1 to the acknowledge register, and only after that handles the next message.
- R7: Major code 0x0007 sets `done_o` and `pass_o`. Both stay high until reset.
- R8: Major code 0x00FF sets `done_o` and `fail_o`. No bus request follows until reset.
- R9: Major code 0x0008 makes the next message a count word (tag 1) whose low 16 bits give N. Exactly N argument words (tag 2) follow, and then the block returns to major messages. N = 0 returns at once.
- R10: Any other major code is output with tag 0 and otherwise ignored.
- R11: When POLL_LIMIT consecutive status reads in one wait do not show the awaited bit value, `done_o` and `timeout_o` rise, `pass_o` and `fail_o` stay low, and requests stop.
- R12: `msg_valid_o` is high for exactly one cycle per received word.
- R13: `start_i` has no effect once `done_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin monitoring |
| bus_req_o | output | 1 | Register access request |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | 32 | Byte address |
| bus_wdata_o | output | 32 | Write data |
| bus_ack_i | input | 1 | Access complete; read data valid |
| bus_rdata_i | input | 32 | Read data |
| msg_valid_o | output | 1 | One-cycle strobe for a received word |
| msg_tag_o | output | 2 | 0 major, 1 count, 2 argument |
| msg_data_o | output | 32 | Received word |
| done_o | output | 1 | Monitoring finished (sticky) |
| pass_o | output | 1 | Training passed (sticky) |
| fail_o | output | 1 | Training failed (sticky) |
| timeout_o | output | 1 | Poll limit exceeded (sticky) |

## Verification
Suppose the message kind or the remaining count is corrupted. Then the next received word shows up with the wrong tag, or the high register is read when it should not be (or skipped when it should be read). The scoreboard or the engine model catches this at the next data read, within a few tens of cycles. A fault in the handshake ordering shows at the port right away: a data read comes while no message is posted, or an acknowledge write arrives before the cleared status has been seen. A faulty verdict or poll counter shows up in the sticky flags, or in the exact number of status reads made before a timeout.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int unsigned DW    = 32;
  localparam int unsigned AW    = 32;
  localparam int unsigned HW    = 16;

  localparam logic [AW-1:0] IDX_STATUS = 32'h000d_0004;
  localparam logic [AW-1:0] IDX_ACK    = 32'h000d_0031;
  localparam logic [AW-1:0] IDX_LO     = 32'h000d_0032;
  localparam logic [AW-1:0] IDX_HI     = 32'h000d_0034;

  localparam logic [HW-1:0] CODE_PASS   = 16'h0007;
  localparam logic [HW-1:0] CODE_STREAM = 16'h0008;
  localparam logic [HW-1:0] CODE_FAIL   = 16'h00ff;

  typedef enum logic [1:0] {
    TAG_MAJOR = 2'd0,
    TAG_COUNT = 2'd1,
    TAG_ARG   = 2'd2
  } msg_tag_e;

  typedef struct packed {
    logic          we;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
  } bus_cmd_t;

  function automatic logic [AW-1:0] reg_addr(input logic [AW-1:0] base,
                                             input logic [AW-1:0] idx);
    return base + (idx << 2);
  endfunction
endpackage

// File: rtl/mbox_bus_master.sv
module mbox_bus_master
  import mbox_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  bus_cmd_t      cmd_i,
  output logic          req_o,
  output logic          we_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  input  logic          ack_i,
  input  logic [DW-1:0] rdata_i,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_data_o
);
  bus_cmd_t cmd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_o       <= 1'b0;
      cmd_q       <= '0;
      rsp_valid_o <= 1'b0;
      rsp_data_o  <= '0;
    end else begin
      rsp_valid_o <= 1'b0;
      if (req_o && ack_i) begin
        req_o       <= 1'b0;
        rsp_valid_o <= 1'b1;
        rsp_data_o  <= rdata_i;
      end else if (go_i && !req_o) begin
        req_o <= 1'b1;
        cmd_q <= cmd_i;
      end
    end
  end

  assign we_o    = cmd_q.we;
  assign addr_o  = cmd_q.addr;
  assign wdata_o = cmd_q.wdata;
endmodule

// File: rtl/mbox_poll_timer.sv
module mbox_poll_timer #(
  parameter int unsigned LIMIT = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic expired_o
);
  localparam int unsigned CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);

  logic [CW-1:0] cnt_q;

  assign expired_o = inc_i && (cnt_q == CW'(LIMIT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i)             cnt_q <= '0;
    else if (inc_i && !expired_o) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/mbox_seq.sv
module mbox_seq
  import mbox_pkg::*;
#(
  parameter logic [AW-1:0] BASE_ADDR = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          go_o,
  output bus_cmd_t      cmd_o,
  input  logic          rsp_valid_i,
  input  logic [DW-1:0] rsp_data_i,
  output logic          tmr_clr_o,
  output logic          tmr_inc_o,
  input  logic          tmr_exp_i,
  output logic          msg_valid_o,
  output logic [1:0]    msg_tag_o,
  output logic [DW-1:0] msg_data_o,
  output logic          done_o,
  output logic          pass_o,
  output logic          fail_o,
  output logic          timeout_o
);
  localparam logic [AW-1:0] A_STATUS = reg_addr(BASE_ADDR, IDX_STATUS);
  localparam logic [AW-1:0] A_ACK    = reg_addr(BASE_ADDR, IDX_ACK);
  localparam logic [AW-1:0] A_LO     = reg_addr(BASE_ADDR, IDX_LO);
  localparam logic [AW-1:0] A_HI     = reg_addr(BASE_ADDR, IDX_HI);

  typedef enum logic [2:0] {
    ST_IDLE, ST_POLL_SET, ST_RD_HI, ST_RD_LO,
    ST_ACK_CLR, ST_POLL_CLR, ST_ACK_SET, ST_HALT
  } state_e;

  state_e          state_q;
  msg_tag_e        kind_q;
  logic            issued_q;
  logic [HW-1:0]   hi_q;
  logic [HW-1:0]   remain_q;
  logic [DW-1:0]   word_q;
  logic            bus_st, is_poll, poll_ok;
  logic [DW-1:0]   word_d;

  always_comb begin
    cmd_o  = '0;
    bus_st = 1'b1;
    unique case (state_q)
      ST_POLL_SET, ST_POLL_CLR: cmd_o.addr = A_STATUS;
      ST_RD_HI:   cmd_o.addr = A_HI;
      ST_RD_LO:   cmd_o.addr = A_LO;
      ST_ACK_CLR: begin cmd_o.we = 1'b1; cmd_o.addr = A_ACK; end
      ST_ACK_SET: begin cmd_o.we = 1'b1; cmd_o.addr = A_ACK; cmd_o.wdata = 32'd1; end
      default:    bus_st = 1'b0;
    endcase
  end

  assign go_o      = bus_st && !issued_q;
  assign is_poll   = (state_q == ST_POLL_SET) || (state_q == ST_POLL_CLR);
  assign poll_ok   = (state_q == ST_POLL_SET) ? ~rsp_data_i[0] : rsp_data_i[0];
  assign tmr_inc_o = rsp_valid_i && is_poll && !poll_ok;
  assign tmr_clr_o = rsp_valid_i && is_poll && poll_ok;
  assign word_d    = (kind_q == TAG_MAJOR) ? {{(DW-HW){1'b0}}, rsp_data_i[HW-1:0]}
                                           : {hi_q, rsp_data_i[HW-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      kind_q      <= TAG_MAJOR;
      issued_q    <= 1'b0;
      hi_q        <= '0;
      remain_q    <= '0;
      word_q      <= '0;
      msg_valid_o <= 1'b0;
      msg_tag_o   <= '0;
      msg_data_o  <= '0;
      done_o      <= 1'b0;
      pass_o      <= 1'b0;
      fail_o      <= 1'b0;
      timeout_o   <= 1'b0;
    end else begin
      msg_valid_o <= 1'b0;
      if (go_o) issued_q <= 1'b1;
      if (state_q == ST_IDLE) begin
        if (start_i) begin
          state_q <= ST_POLL_SET;
          kind_q  <= TAG_MAJOR;
        end
      end else if (rsp_valid_i) begin
        issued_q <= 1'b0;
        unique case (state_q)
          ST_POLL_SET, ST_POLL_CLR: begin
            if (poll_ok) begin
              if (state_q == ST_POLL_CLR)   state_q <= ST_ACK_SET;
              else if (kind_q == TAG_MAJOR) state_q <= ST_RD_LO;
              else                          state_q <= ST_RD_HI;
            end else if (tmr_exp_i) begin
              state_q   <= ST_HALT;
              done_o    <= 1'b1;
              timeout_o <= 1'b1;
            end
          end
          ST_RD_HI: begin
            hi_q    <= rsp_data_i[HW-1:0];
            state_q <= ST_RD_LO;
          end
          ST_RD_LO: begin
            word_q      <= word_d;
            msg_valid_o <= 1'b1;
            msg_tag_o   <= kind_q;
            msg_data_o  <= word_d;
            state_q     <= ST_ACK_CLR;
          end
          ST_ACK_CLR: state_q <= ST_POLL_CLR;
          ST_ACK_SET: begin
            state_q <= ST_POLL_SET;
            unique case (kind_q)
              TAG_MAJOR: begin
                if (word_q[HW-1:0] == CODE_PASS) begin
                  state_q <= ST_HALT;
                  done_o  <= 1'b1;
                  pass_o  <= 1'b1;
                end else if (word_q[HW-1:0] == CODE_FAIL) begin
                  state_q <= ST_HALT;
                  done_o  <= 1'b1;
                  fail_o  <= 1'b1;
                end else if (word_q[HW-1:0] == CODE_STREAM) begin
                  kind_q <= TAG_COUNT;
                end
              end
              TAG_COUNT: begin
                remain_q <= word_q[HW-1:0];
                kind_q   <= (word_q[HW-1:0] == '0) ? TAG_MAJOR : TAG_ARG;
              end
              default: begin
                remain_q <= remain_q - 1'b1;
                if (remain_q == HW'(1)) kind_q <= TAG_MAJOR;
              end
            endcase
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/mbox_monitor.sv
module mbox_monitor
  import mbox_pkg::*;
#(
  parameter logic [31:0] BASE_ADDR  = 32'h0,
  parameter int unsigned POLL_LIMIT = 256
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  output logic        bus_req_o,
  output logic        bus_we_o,
  output logic [31:0] bus_addr_o,
  output logic [31:0] bus_wdata_o,
  input  logic        bus_ack_i,
  input  logic [31:0] bus_rdata_i,
  output logic        msg_valid_o,
  output logic [1:0]  msg_tag_o,
  output logic [31:0] msg_data_o,
  output logic        done_o,
  output logic        pass_o,
  output logic        fail_o,
  output logic        timeout_o
);
  logic          go, rsp_valid, tmr_clr, tmr_inc, tmr_exp;
  bus_cmd_t      cmd;
  logic [DW-1:0] rsp_data;

  mbox_bus_master u_bus (
    .clk_i, .rst_ni,
    .go_i(go), .cmd_i(cmd),
    .req_o(bus_req_o), .we_o(bus_we_o), .addr_o(bus_addr_o), .wdata_o(bus_wdata_o),
    .ack_i(bus_ack_i), .rdata_i(bus_rdata_i),
    .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data)
  );

  mbox_poll_timer #(.LIMIT(POLL_LIMIT)) u_tmr (
    .clk_i, .rst_ni, .clr_i(tmr_clr), .inc_i(tmr_inc), .expired_o(tmr_exp)
  );

  mbox_seq #(.BASE_ADDR(BASE_ADDR)) u_seq (
    .clk_i, .rst_ni, .start_i,
    .go_o(go), .cmd_o(cmd),
    .rsp_valid_i(rsp_valid), .rsp_data_i(rsp_data),
    .tmr_clr_o(tmr_clr), .tmr_inc_o(tmr_inc), .tmr_exp_i(tmr_exp),
    .msg_valid_o, .msg_tag_o, .msg_data_o,
    .done_o, .pass_o, .fail_o, .timeout_o
  );
endmodule

// File: rtl/mbox_monitor_chk.sv
module mbox_monitor_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic        bus_req_o,
  input logic        bus_we_o,
  input logic [31:0] bus_addr_o,
  input logic [31:0] bus_wdata_o,
  input logic        bus_ack_i,
  input logic        msg_valid_o,
  input logic        done_o,
  input logic        pass_o,
  input logic        fail_o,
  input logic        timeout_o
);
  logic started_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) started_q <= 1'b0;
    else         started_q <= started_q | start_i;
  end

  p_quiet_before_start_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !started_q |-> !bus_req_o);

  p_req_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_ack_i |=> bus_req_o && $stable(bus_addr_o) &&
                                $stable(bus_we_o) && $stable(bus_wdata_o));

  p_single_beat_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_ack_i |=> !bus_req_o);

  p_done_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o && $stable({pass_o, fail_o, timeout_o}));

  p_one_verdict_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({pass_o, fail_o, timeout_o}) == (done_o ? 1 : 0));

  p_halt_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !bus_req_o);

  p_valid_pulse_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o |=> !msg_valid_o);
endmodule

bind mbox_monitor mbox_monitor_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
  .bus_req_o(bus_req_o), .bus_we_o(bus_we_o), .bus_addr_o(bus_addr_o),
  .bus_wdata_o(bus_wdata_o), .bus_ack_i(bus_ack_i), .msg_valid_o(msg_valid_o),
  .done_o(done_o), .pass_o(pass_o), .fail_o(fail_o), .timeout_o(timeout_o)
);

// File: tb/mbox_monitor_bench.sv
module mbox_monitor_bench;
  localparam int unsigned LIMIT = 256;
  localparam logic [31:0] A_STATUS = 32'h0034_0010;
  localparam logic [31:0] A_ACK    = 32'h0034_00C4;
  localparam logic [31:0] A_LO     = 32'h0034_00C8;
  localparam logic [31:0] A_HI     = 32'h0034_00D0;

  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic        req, we, ack = 1'b0, mvalid, done, pass, fail, tout;
  logic [31:0] addr, wdata, rdata = '0, mdata;
  logic [1:0]  mtag;

  always #4 clk = ~clk;

  mbox_monitor #(.BASE_ADDR(32'h0), .POLL_LIMIT(LIMIT)) u_mbox_monitor (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .bus_req_o(req), .bus_we_o(we), .bus_addr_o(addr), .bus_wdata_o(wdata),
    .bus_ack_i(ack), .bus_rdata_i(rdata),
    .msg_valid_o(mvalid), .msg_tag_o(mtag), .msg_data_o(mdata),
    .done_o(done), .pass_o(pass), .fail_o(fail), .timeout_o(tout)
  );

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  // engine model
  logic [31:0] scr_w[$];
  bit          scr_s[$];
  logic [31:0] exp_d[$];
  logic [1:0]  exp_t[$];
  bit pending, ack_reg, seen_low, seen_high, hi_done, lo_done;
  int clr_cnt, post_cnt;
  int v_r3, v_r5, v_r6, v_r2, v_r12, n_status, n_ack0, n_req;
  bit prev_req, prev_ack, prev_valid, prev_we;
  logic [31:0] prev_addr, prev_wdata;

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic add_major(input logic [15:0] code);
    scr_w.push_back({16'hDEAD, code}); scr_s.push_back(1'b0);
    exp_d.push_back({16'h0, code});    exp_t.push_back(2'd0);
  endtask

  task automatic add_stream(input logic [31:0] w, input logic [1:0] tag);
    scr_w.push_back(w); scr_s.push_back(1'b1);
    exp_d.push_back(w); exp_t.push_back(tag);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; start = 1'b0;
    scr_w.delete(); scr_s.delete(); exp_d.delete(); exp_t.delete();
    pending = 0; ack_reg = 1; seen_low = 0; seen_high = 0; hi_done = 0; lo_done = 0;
    clr_cnt = -1; post_cnt = 4;
    v_r3 = 0; v_r5 = 0; v_r6 = 0; v_r2 = 0; v_r12 = 0;
    n_status = 0; n_ack0 = 0; n_req = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done(input int max);
    for (int i = 0; i < max && !done; i++) @(negedge clk);
    #1;
  endtask

  // slave, engine and scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        // engine timers
        if (clr_cnt > 0) clr_cnt--;
        if (clr_cnt == 0) begin
          pending = 0; clr_cnt = -1;
          void'(scr_w.pop_front()); void'(scr_s.pop_front());
        end
        if (!pending && ack_reg && clr_cnt < 0 && scr_w.size() > 0) begin
          if (post_cnt > 0) post_cnt--;
          else begin
            pending = 1; seen_low = 0; seen_high = 0; hi_done = 0; lo_done = 0;
          end
        end
        // R2 monitor
        if (prev_req && !prev_ack) begin
          if (!req || addr != prev_addr || we != prev_we || wdata != prev_wdata) v_r2++;
        end
        if (prev_req && prev_ack && req) v_r2++;
        if (req && !prev_req) n_req++;
        // slave response
        if (ack) ack = 1'b0;
        else if (req) begin
          ack = 1'b1; rdata = 32'h5A5A_0000;
          if (!we && addr == A_STATUS) begin
            n_status++;
            rdata = {31'h0, ~pending};
            if (pending) seen_low = 1;
            else if (!ack_reg) seen_high = 1;
          end else if (!we && addr == A_HI) begin
            if (!pending || !seen_low) v_r3++;
            if (scr_w.size() == 0 || !scr_s[0] || lo_done) v_r5++;
            hi_done = 1;
            if (scr_w.size() > 0) rdata = {16'h5A5A, scr_w[0][31:16]};
          end else if (!we && addr == A_LO) begin
            if (!pending || !seen_low || !ack_reg) v_r3++;
            if (scr_w.size() > 0 && scr_s[0] && !hi_done) v_r5++;
            lo_done = 1;
            if (scr_w.size() > 0) rdata = {16'h5A5A, scr_w[0][15:0]};
          end else if (we && addr == A_ACK && wdata == 32'd0) begin
            if (!pending || !lo_done || !ack_reg) v_r6++;
            ack_reg = 0; clr_cnt = 3; n_ack0++;
          end else if (we && addr == A_ACK && wdata == 32'd1) begin
            if (pending || ack_reg || !seen_high) v_r6++;
            ack_reg = 1; post_cnt = 4;
          end else v_r6++;
        end
        // scoreboard
        if (mvalid) begin
          if (prev_valid) v_r12++;
          if (exp_d.size() == 0) chk(0, "R4/R9 unexpected word", mdata, 32'h0);
          else begin
            logic [31:0] ed; logic [1:0] et;
            ed = exp_d.pop_front(); et = exp_t.pop_front();
            chk(mdata == ed && mtag == et,
                (et == 2'd0) ? "R4/R10 major word" : ((et == 2'd1) ? "R9 count word" : "R5/R9 argument word"),
                {mtag, mdata[29:0]}, {et, ed[29:0]});
          end
        end
      end
      prev_req = req; prev_ack = ack; prev_valid = mvalid;
      prev_addr = addr; prev_we = we; prev_wdata = wdata;
    end
  end

  task automatic check_protocol(input string tag);
    chk(v_r2 == 0, {"R2 request hold ", tag}, v_r2, 0);
    chk(v_r3 == 0, {"R3 read before pending ", tag}, v_r3, 0);
    chk(v_r5 == 0, {"R5 high/low order ", tag}, v_r5, 0);
    chk(v_r6 == 0, {"R6 ack handshake ", tag}, v_r6, 0);
    chk(v_r12 == 0, {"R12 valid pulse ", tag}, v_r12, 0);
  endtask

  initial begin
    int reqs;
    // Test A: stream mix ending in pass
    do_reset();
    chk({req, mvalid, done, pass, fail, tout} == 6'b0, "R1 reset outputs",
        {req, mvalid, done, pass, fail, tout}, 0);
    repeat (20) @(negedge clk);
    chk(n_req == 0, "R1 no request before start", n_req, 0);
    add_major(16'h0001);
    add_major(16'h0008);
    add_stream(32'h0000_0003, 2'd1);
    add_stream(32'h1234_5678, 2'd2);
    add_stream(32'hFFFF_0001, 2'd2);
    add_stream(32'h0007_00FF, 2'd2);
    add_major(16'h0008);
    add_stream(32'hABCD_0000, 2'd1);
    add_major(16'h0055);
    add_major(16'h0007);
    pulse_start();
    wait_done(20000);
    chk(done && pass && !fail && !tout, "R7 pass verdict", {done, pass, fail, tout}, 4'b1100);
    chk(exp_d.size() == 0, "R9 all words received", exp_d.size(), 0);
    chk(n_ack0 == 10, "R6 one ack per message", n_ack0, 10);
    check_protocol("A");
    reqs = n_req;
    pulse_start();
    repeat (50) @(negedge clk);
    chk(n_req == reqs, "R13 start after done ignored", n_req, reqs);
    chk(done && pass, "R7 pass sticky", {done, pass}, 2'b11);

    // Test B: fail, with a leftover message
    do_reset();
    add_major(16'h0012);
    add_major(16'h00FF);
    scr_w.push_back(32'h0000_0007); scr_s.push_back(1'b0);
    pulse_start();
    wait_done(20000);
    chk(done && fail && !pass && !tout, "R8 fail verdict", {done, pass, fail, tout}, 4'b1010);
    reqs = n_req;
    repeat (100) @(negedge clk);
    chk(n_req == reqs, "R8 no requests after fail", n_req, reqs);
    chk(scr_w.size() == 1, "R8 later message untouched", scr_w.size(), 1);
    chk(fail && !pass, "R8 fail sticky", {pass, fail}, 2'b01);
    check_protocol("B");

    // Test C: nothing posted, timeout
    do_reset();
    pulse_start();
    wait_done(20000);
    chk(done && tout && !pass && !fail, "R11 timeout verdict", {done, pass, fail, tout}, 4'b1001);
    chk(n_status == LIMIT, "R11 status reads before timeout", n_status, LIMIT);
    reqs = n_req;
    repeat (50) @(negedge clk);
    chk(n_req == reqs, "R11 no requests after timeout", n_req, reqs);
    check_protocol("C");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule